// File: doc/BRIEF.md
# Radix-4 Recoded Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full `2*WIDTH`-bit signed product. The multiplier operand is scanned in overlapping three-bit windows, two bit positions apart. Each window picks one signed digit from the set {-2, -1, 0, +1, +2}. That digit selects zero, the multiplicand, twice the multiplicand, or the negation of either as one partial product. There are `WIDTH/2` partial products, half the count that one-bit-at-a-time recoding gives. Each one is sign-extended to the product width, weighted by four to the power of its window index, and summed by a chain of adders.

Operands enter and the product leaves through valid/ready streams. With `REGISTERED = 1` (the default), operands go into an input stage and the product goes into an output stage. This gives a fixed two-cycle latency and a throughput of one pair per cycle. Back-pressure stalls both stages together: while the output holds a product that has not been taken, `in_ready` is low and nothing moves. With `REGISTERED = 0`, the path is purely combinational. In that mode `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. `WIDTH` must be even, and an odd value stops elaboration.

Top module: `booth_r4_mul`

## Requirements
- R1: When `out_valid` is high, `out_prod` equals the signed product of the accepted multiplier and multiplicand, computed exactly in `2*WIDTH` bits. This includes the case where both operands are most negative, which gives +2^(2*WIDTH-2).
- R2: Window i reads multiplier bits (2i+1, 2i, 2i-1), with the bit below bit 0 read as 0. The window values map to digits as follows: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives -2; 101 and 110 give -1. Products of multipliers such as 0x55, 0xAA, 0x66 and 0x33, which use every digit, must be exact.
- R3: A pair accepted at a rising edge while `out_ready` stays high appears on `out_prod`, with `out_valid` high, after the second rising edge that follows. It does not appear after the first.
- R4: While `out_ready` is high, `in_ready` stays high. Pairs offered on consecutive cycles give results on consecutive cycles, in the order they were offered.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_prod` keep their values at the next edge.
- R6: While `rst_n` is low and just after it is released, `out_valid` is low and `in_ready` is high.
- R7: A cycle with `in_valid` low produces no result: `out_valid` is low two edges later, and no extra result is ever emitted.
- R8: A zero operand on either side gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Operand pair taken when high together with in_valid |
| in_mplier | input | WIDTH | Multiplier operand, signed; this is the operand that gets recoded |
| in_mcand | input | WIDTH | Multiplicand operand, signed |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 2*WIDTH | Signed product |

## Verification
A mistake in one recoding window shows at the ports two cycles after the pair is accepted. It appears as a product that is wrong by a multiple of the multiplicand, weighted by four to the power of that window's index. The vector set therefore exercises every window code, as well as the most-negative and all-ones operands. A fault in the stage-enable logic shows up differently. It can appear as a result that is dropped, duplicated or reordered within a back-to-back stream. It can also appear as an output that changes while it is stalled; this is visible in the cycle after `out_ready` drops.

// File: rtl/booth_r4_pkg.sv
package booth_r4_pkg;

  // Signed radix-4 digit: magnitude one-hot (one/two), sign separately.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_digit_t;

  function automatic booth_digit_t recode_window(input logic [2:0] win);
    booth_digit_t d;
    d = '0;
    unique case (win)
      3'b000, 3'b111: d = '0;
      3'b001, 3'b010: begin d.one = 1'b1; end
      3'b011:         begin d.two = 1'b1; end
      3'b100:         begin d.two = 1'b1; d.neg = 1'b1; end
      3'b101, 3'b110: begin d.one = 1'b1; d.neg = 1'b1; end
      default:        d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/booth_r4_recoder.sv
module booth_r4_recoder
  import booth_r4_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int NDIG = WIDTH / 2
) (
  input  logic [WIDTH-1:0]         mplier,
  output booth_digit_t [NDIG-1:0]  digits
);

  for (genvar gi = 0; gi < NDIG; gi++) begin : g_win
    logic [2:0] win;
    if (gi == 0) begin : g_low
      assign win = {mplier[1], mplier[0], 1'b0};
    end else begin : g_mid
      assign win = {mplier[2*gi+1], mplier[2*gi], mplier[2*gi-1]};
    end
    assign digits[gi] = recode_window(win);
  end

endmodule

// File: rtl/booth_r4_ppgen.sv
module booth_r4_ppgen
  import booth_r4_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int INDEX = 0,
  localparam int PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] mcand,
  input  booth_digit_t     digit,
  output logic [PW-1:0]    pp
);

  logic [PW-1:0] mcand_ext;
  logic [PW-1:0] mag;
  logic [PW-1:0] signed_val;

  assign mcand_ext = {{WIDTH{mcand[WIDTH-1]}}, mcand};

  always_comb begin
    if (digit.two)      mag = mcand_ext << 1;
    else if (digit.one) mag = mcand_ext;
    else                mag = '0;
    signed_val = digit.neg ? (~mag + 1'b1) : mag;
  end

  assign pp = signed_val << (2 * INDEX);

endmodule

// File: rtl/booth_r4_sum.sv
module booth_r4_sum #(
  parameter int NTERMS = 4,
  parameter int PW     = 16
) (
  input  logic [NTERMS-1:0][PW-1:0] terms,
  output logic [PW-1:0]             total
);

  logic [NTERMS-1:0][PW-1:0] acc;

  assign acc[0] = terms[0];
  for (genvar gi = 1; gi < NTERMS; gi++) begin : g_chain
    assign acc[gi] = acc[gi-1] + terms[gi];
  end
  assign total = acc[NTERMS-1];

endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul
  import booth_r4_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int NDIG = WIDTH / 2,
  localparam int PW   = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_mplier,
  input  logic [WIDTH-1:0] in_mcand,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PW-1:0]    out_prod
);

  if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
    $error("booth_r4_mul: WIDTH must be even and at least 2");
  end

  logic [WIDTH-1:0]         core_mplier;
  logic [WIDTH-1:0]         core_mcand;
  logic [PW-1:0]            core_prod;
  booth_digit_t [NDIG-1:0]  digits;
  logic [NDIG-1:0][PW-1:0]  pps;

  booth_r4_recoder #(.WIDTH(WIDTH)) u_rec (
    .mplier (core_mplier),
    .digits (digits)
  );

  for (genvar gi = 0; gi < NDIG; gi++) begin : g_pp
    booth_r4_ppgen #(.WIDTH(WIDTH), .INDEX(gi)) u_ppgen (
      .mcand (core_mcand),
      .digit (digits[gi]),
      .pp    (pps[gi])
    );
  end

  booth_r4_sum #(.NTERMS(NDIG), .PW(PW)) u_sum (
    .terms (pps),
    .total (core_prod)
  );

  if (REGISTERED) begin : g_reg
    logic             adv;
    logic             s1_valid;
    logic [WIDTH-1:0] s1_mplier;
    logic [WIDTH-1:0] s1_mcand;
    logic             s2_valid;
    logic [PW-1:0]    s2_prod;

    // Whole pipe moves together unless the output is held.
    assign adv = !s2_valid || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_valid  <= 1'b0;
        s1_mplier <= '0;
        s1_mcand  <= '0;
        s2_valid  <= 1'b0;
        s2_prod   <= '0;
      end else if (adv) begin
        s1_valid  <= in_valid;
        s1_mplier <= in_mplier;
        s1_mcand  <= in_mcand;
        s2_valid  <= s1_valid;
        s2_prod   <= core_prod;
      end
    end

    assign core_mplier = s1_mplier;
    assign core_mcand  = s1_mcand;
    assign in_ready    = adv;
    assign out_valid   = s2_valid;
    assign out_prod    = s2_prod;
  end else begin : g_comb
    assign core_mplier = in_mplier;
    assign core_mcand  = in_mcand;
    assign in_ready    = out_ready;
    assign out_valid   = in_valid;
    assign out_prod    = core_prod;
  end

endmodule

// File: rtl/booth_r4_mul_chk.sv
module booth_r4_mul_chk #(
  parameter int WIDTH      = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int PW = 2 * WIDTH
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_mplier,
  input logic [WIDTH-1:0] in_mcand,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PW-1:0]    out_prod
);

  function automatic logic [PW-1:0] ref_mul(input logic [WIDTH-1:0] a,
                                            input logic [WIDTH-1:0] b);
    logic signed [PW-1:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  if (REGISTERED) begin : g_reg
    logic          sh1_v, sh2_v;
    logic [PW-1:0] sh1_p, sh2_p;

    // Shadow of the expected stream, built from the port handshake.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh1_v <= 1'b0; sh2_v <= 1'b0; sh1_p <= '0; sh2_p <= '0;
      end else if (!sh2_v || out_ready) begin
        sh1_v <= in_valid;
        sh1_p <= ref_mul(in_mplier, in_mcand);
        sh2_v <= sh1_v;
        sh2_p <= sh1_p;
      end
    end

    // R1 / R2 / R8
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_prod == sh2_p));
    // R7
    a_r7_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == sh2_v);
    // R3
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(in_valid && in_ready, 2));
    // R4
    a_r4_ready: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);
    // R5
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));
    a_r5_block: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
    // R6
    always @(negedge clk) begin
      if (!rst_n) begin
        a_r6_reset: assert (!out_valid && in_ready);
      end
    end
  end else begin : g_comb
    always @(negedge clk) begin
      if (rst_n && out_valid) begin
        a_r1_product: assert (out_prod == ref_mul(in_mplier, in_mcand));
      end
      a_r4_ready: assert (in_ready == out_ready);
      a_r7_no_extra: assert (out_valid == in_valid);
    end
  end

endmodule

bind booth_r4_mul booth_r4_mul_chk #(.WIDTH(WIDTH), .REGISTERED(REGISTERED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mplier (in_mplier),
  .in_mcand  (in_mcand),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod)
);

// File: tb/test_booth_r4_mul.sv
module test_booth_r4_mul;

  localparam int NT  = 16;
  localparam int NR  = 24;
  localparam int NS  = NT + NR;

  // Table: multiplier, multiplicand, expected 16-bit product (8-bit operands).
  localparam logic [7:0] T_A [NT] = '{8'h9D, 8'h80, 8'h80, 8'h7F, 8'h7F, 8'hFF, 8'hFF, 8'h00,
                                      8'h80, 8'h55, 8'hAA, 8'h66, 8'h33, 8'h01, 8'h02, 8'hFE};
  localparam logic [7:0] T_B [NT] = '{8'h8A, 8'h80, 8'h7F, 8'h80, 8'h7F, 8'hFF, 8'h80, 8'h80,
                                      8'h00, 8'h03, 8'h07, 8'hF9, 8'h80, 8'hC8, 8'h64, 8'h64};
  localparam logic [15:0] T_P [NT] = '{16'h2DA2, 16'h4000, 16'hC080, 16'hC080, 16'h3F01,
                                       16'h0001, 16'h0080, 16'h0000, 16'h0000, 16'h00FF,
                                       16'hFDA6, 16'hFD36, 16'hE680, 16'hFFC8, 16'h00C8,
                                       16'hFF38};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic        rdy8, rdy16, ov8, ov16;
  logic [15:0] p8;
  logic [31:0] p16;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  booth_r4_mul #(.WIDTH(8)) i_booth_r4_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy8),
    .in_mplier(a8), .in_mcand(b8), .out_valid(ov8), .out_ready(out_ready),
    .out_prod(p8)
  );

  booth_r4_mul #(.WIDTH(16)) i_booth_r4_mul_w16 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy16),
    .in_mplier(a16), .in_mcand(b16), .out_valid(ov16), .out_ready(out_ready),
    .out_prod(p16)
  );

  logic [7:0]  sa8 [NS];
  logic [7:0]  sb8 [NS];
  logic [15:0] se8 [NS];
  logic [15:0] sa16 [NS];
  logic [15:0] sb16 [NS];
  logic [31:0] se16 [NS];

  function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  function automatic logic [31:0] ref16(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
      finish_run();
    end
  end

  initial begin : main
    // Build stimulus: table rows, 16-bit corners, then random pairs.
    for (int i = 0; i < NS; i++) begin
      if (i < NT) begin
        sa8[i] = T_A[i]; sb8[i] = T_B[i]; se8[i] = T_P[i];
      end else begin
        sa8[i] = 8'($urandom()); sb8[i] = 8'($urandom());
        se8[i] = ref8(sa8[i], sb8[i]);
      end
      sa16[i] = 16'($urandom()); sb16[i] = 16'($urandom());
    end
    sa16[0] = 16'h8000; sb16[0] = 16'h8000;
    sa16[1] = 16'hFFFF; sb16[1] = 16'hFFFF;
    sa16[2] = 16'h0000; sb16[2] = 16'h8000;
    sa16[3] = 16'h8000; sb16[3] = 16'h7FFF;
    sa16[4] = 16'h5555; sb16[4] = 16'h8001;
    sa16[5] = 16'hAAAA; sb16[5] = 16'h7FFF;
    for (int i = 0; i < NS; i++) se16[i] = ref16(sa16[i], sb16[i]);

    // R6: reset state.
    repeat (3) @(negedge clk);
    check(!ov8 && !ov16, "R6 out_valid in reset", {30'd0, ov16, ov8}, 0);
    check(rdy8 && rdy16, "R6 in_ready in reset", {30'd0, rdy16, rdy8}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ov8 && !ov16, "R6 out_valid after release", {30'd0, ov16, ov8}, 0);

    // Stream every vector back to back; results lag two negedges.
    for (int k = 0; k < NS + 2; k++) begin
      if (k >= 2) begin
        check(ov8 && p8 == se8[k-2],
              (k - 2 < NT) ? "R1/R2 table product w8" : "R1 random product w8",
              {16'd0, p8}, {16'd0, se8[k-2]});
        check(ov16 && p16 == se16[k-2], "R1 product w16", p16, se16[k-2]);
        if (sa8[k-2] == 0 || sb8[k-2] == 0)
          check(p8 == 0, "R8 zero operand", {16'd0, p8}, 0);
      end
      check(rdy8 && rdy16, "R4 in_ready while streaming", {30'd0, rdy16, rdy8}, 3);
      if (k < NS) begin
        in_valid = 1'b1;
        a8 = sa8[k]; b8 = sb8[k]; a16 = sa16[k]; b16 = sb16[k];
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(!ov8 && !ov16, "R7 no extra result after stream", {30'd0, ov16, ov8}, 0);

    // R3: single pair, not visible after one edge, visible after two.
    in_valid = 1'b1; a8 = 8'h9D; b8 = 8'h8A; a16 = 16'h8000; b16 = 16'h8000;
    @(negedge clk);
    in_valid = 1'b0;
    check(!ov8, "R3 not after one edge", {31'd0, ov8}, 0);
    @(negedge clk);
    check(ov8 && p8 == 16'h2DA2, "R3 result after two edges", {16'd0, p8}, 32'h2DA2);
    check(ov16 && p16 == 32'h40000000, "R1 most negative w16", p16, 32'h40000000);
    @(negedge clk);
    check(!ov8, "R7 bubble gives no result", {31'd0, ov8}, 0);

    // R5: back-pressure with two pairs in flight.
    out_ready = 1'b0;
    in_valid = 1'b1; a8 = 8'h66; b8 = 8'hF9; a16 = 16'h0003; b16 = 16'hFFFF;
    @(negedge clk);
    a8 = 8'hAA; b8 = 8'h07; a16 = 16'h0002; b16 = 16'h0005;
    @(negedge clk);
    in_valid = 1'b0;
    check(ov8 && p8 == 16'hFD36, "R5 first held result", {16'd0, p8}, 32'hFD36);
    check(!rdy8, "R5 in_ready low while stalled", {31'd0, rdy8}, 0);
    @(negedge clk);
    check(ov8 && p8 == 16'hFD36, "R5 result stable under stall", {16'd0, p8}, 32'hFD36);
    check(ov16 && p16 == 32'hFFFFFFFD, "R5 w16 result stable", p16, 32'hFFFFFFFD);
    out_ready = 1'b1;
    @(negedge clk);
    check(ov8 && p8 == 16'hFDA6, "R5 second result after release", {16'd0, p8}, 32'hFDA6);
    check(ov16 && p16 == 32'h0000000A, "R4 order w16", p16, 32'h0000000A);
    @(negedge clk);
    check(!ov8 && !ov16, "R7 drained", {30'd0, ov16, ov8}, 0);

    done = 1'b1;
    finish_run();
  end

endmodule